// File: doc/BRIEF.md
# Address Tenure Termination Controller

This controller closes the address phase of a split-transaction processor bus. After a transfer start, it listens for a fixed number of cycles for a claim from an external second-level cache. If the cache claims the tenure, the cache is responsible for the acknowledge. The controller leaves its own acknowledge driver floating and waits until it sees the cache pull the shared line low. If no claim arrives before the delay runs out, the controller drives the acknowledge itself. It drives the line low for one cycle, then drives it high for one cycle, then releases it.

On either path, the cycle that follows the acknowledge is the snoop-retry window. The controller samples the retry line at the end of that cycle. It then emits a one-cycle report saying whether the tenure completed or has to be retried.

The acknowledge, claim and retry pins are all active-low. The acknowledge is split into a drive value and an output enable, so that it can be joined to a shared tri-state line. The acknowledge delay is set by the parameter `ACK_DLY`, which must be at least 1.

Top module: `addr_tenure_term`

## Requirements
- R1: During and after reset, `aack_oe_o` is 0, `aack_n_o` is 1 and `done_valid_o` is 0.
- R2: Take the rising edge where `ts_i` is first seen high while idle as edge k. `hit_n_i` is sampled at edges k+1 through k+ACK_DLY. If it is sampled low at any of them, `aack_oe_o` stays 0 for the whole tenure.
- R3: If `hit_n_i` is high at all of those edges, then from edge k+ACK_DLY the controller drives the line low (`aack_oe_o`=1, `aack_n_o`=0).
- R4: A self-driven acknowledge lasts exactly one cycle driven low and one cycle driven high, and then `aack_oe_o` returns to 0.
- R5: On the self-driven path, `artry_n_i` is sampled at edge k+ACK_DLY+2. `done_valid_o` is then 1 for exactly one cycle.
- R6: On the cached path, the controller waits for an edge j at which `aack_n_i` is sampled low. It samples `artry_n_i` at edge j+1 and then pulses `done_valid_o`. A low `aack_n_i` sampled before the claim has no effect.
- R7: The claim is ignored when it is low at edge k itself, and when it is low after the controller has begun driving.
- R8: A `ts_i` high while a tenure is open is ignored. Tenures may follow each other back to back: a start at the edge right after the report edge is accepted.
- R9: When `done_valid_o` is 1, `done_retry_o` is 1 if `artry_n_i` was low at the sampling edge and 0 if it was high. A low retry at any other edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_i | input | 1 | Transfer start, active high, one cycle |
| hit_n_i | input | 1 | Cache claim, active low |
| aack_n_i | input | 1 | Shared acknowledge line as seen on the pin, active low |
| artry_n_i | input | 1 | Snoop retry line, active low |
| aack_n_o | output | 1 | Acknowledge drive value, active low |
| aack_oe_o | output | 1 | Acknowledge output enable |
| done_valid_o | output | 1 | One-cycle tenure report strobe |
| done_retry_o | output | 1 | 1 = tenure retried, 0 = completed |

## Verification
The assertions assume three things about the inputs:
- `aack_n_i` is the resolved shared line, which mirrors the controller's own drive whenever `aack_oe_o` is high.
- The cache asserts the acknowledge only after it has claimed the tenure.
- The cache never drives the line while the controller does.

The bench enforces these by resolving the line itself from the two drivers. The cache model acts only on tenures it claimed inside the sampling window, and always at least one cycle after that claim. The bench also flags any cycle in which both drivers are enabled at once.

// File: rtl/att_pkg.sv
package att_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HITWIN,
        ST_CACHE,
        ST_CWIN,
        ST_DRV_LO,
        ST_DRV_HI
    } att_state_e;

    typedef struct packed {
        att_state_e state;
        logic       oe;
        logic       drv_n;
    } att_ctl_s;

endpackage

// File: rtl/att_dly_cnt.sv
module att_dly_cnt #(
    parameter int ACK_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic adv_i,
    output logic expired_o
);
    localparam int CW = $clog2(ACK_DLY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(1);
        else if (adv_i)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == CW'(ACK_DLY));

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(ACK_DLY)); // R3

endmodule

// File: rtl/att_retry_cap.sv
module att_retry_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic artry_i,
    output logic done_valid_o,
    output logic done_retry_o
);
    typedef struct packed {
        logic vld;
        logic rty;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = sample_i;
        if (sample_i)
            cap_d.rty = artry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign done_valid_o = cap_q.vld;
    assign done_retry_o = cap_q.rty;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> !cap_q.vld); // R5

endmodule

// File: rtl/addr_tenure_term.sv
module addr_tenure_term #(
    parameter int ACK_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ts_i,
    input  logic hit_n_i,
    input  logic aack_n_i,
    input  logic artry_n_i,
    output logic aack_n_o,
    output logic aack_oe_o,
    output logic done_valid_o,
    output logic done_retry_o
);
    import att_pkg::*;

    logic hit, line_ack, artry;
    logic cnt_start, cnt_adv, cnt_expired, win_sample;
    att_ctl_s ctl_d, ctl_q;

    assign hit      = ~hit_n_i;
    assign line_ack = ~aack_n_i;
    assign artry    = ~artry_n_i;

    att_dly_cnt #(.ACK_DLY(ACK_DLY)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cnt_start),
        .adv_i     (cnt_adv),
        .expired_o (cnt_expired)
    );

    att_retry_cap u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (win_sample),
        .artry_i      (artry),
        .done_valid_o (done_valid_o),
        .done_retry_o (done_retry_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        cnt_start  = 1'b0;
        cnt_adv    = 1'b0;
        win_sample = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ts_i) begin
                    ctl_d.state = ST_HITWIN;
                    cnt_start   = 1'b1;
                end
            end
            ST_HITWIN: begin
                if (hit) begin
                    ctl_d.state = ST_CACHE;
                end else if (cnt_expired) begin
                    ctl_d.state = ST_DRV_LO;
                    ctl_d.oe    = 1'b1;
                    ctl_d.drv_n = 1'b0;
                end else begin
                    cnt_adv = 1'b1;
                end
            end
            ST_CACHE: begin
                if (line_ack) ctl_d.state = ST_CWIN;
            end
            ST_CWIN: begin
                win_sample  = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            ST_DRV_LO: begin
                ctl_d.state = ST_DRV_HI;
                ctl_d.drv_n = 1'b1;
            end
            ST_DRV_HI: begin
                win_sample  = 1'b1;
                ctl_d.state = ST_IDLE;
                ctl_d.oe    = 1'b0;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, oe: 1'b0, drv_n: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign aack_n_o  = ctl_q.drv_n;
    assign aack_oe_o = ctl_q.oe;

    AST_ENABLE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aack_oe_o) |-> !aack_n_o); // R4
    AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (aack_oe_o && !aack_n_o) |=> (aack_oe_o && aack_n_o)); // R4
    AST_HIGH_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (aack_oe_o && aack_n_o) |=> !aack_oe_o); // R4
    AST_NO_DRIVE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_HITWIN && hit) |=> !aack_oe_o); // R2
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |-> $past(line_ack, 2)); // R6

endmodule

// File: tb/tb_addr_tenure_term.sv
module tb_addr_tenure_term;
    localparam int D = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ts, hit_n, artry_n, c_oe, c_n, line_n;
    logic d_n, d_oe, dv, rt;
    int   checks = 0, fails = 0;
    string cur_req = "R1";
    bit   started = 0;

    always_comb line_n = d_oe ? d_n : (c_oe ? c_n : 1'b1);

    addr_tenure_term #(.ACK_DLY(D)) dut (
        .clk(clk), .rst_n(rst_n), .ts_i(ts), .hit_n_i(hit_n),
        .aack_n_i(line_n), .artry_n_i(artry_n),
        .aack_n_o(d_n), .aack_oe_o(d_oe),
        .done_valid_o(dv), .done_retry_o(rt)
    );

    // behavioural reference: age of the open tenure and who owns the ack
    bit busy, cache, cack;
    int age;
    logic e_oe, e_n, e_dv, e_rt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy = 0; cache = 0; cack = 0; age = 0;
            e_oe = 0; e_n = 1; e_dv = 0; e_rt = 0;
        end else begin
            e_dv = 0;
            if (!busy) begin
                if (ts) begin busy = 1; age = 0; cache = 0; cack = 0; end
            end else begin
                age++;
                if (cache) begin
                    if (cack) begin e_dv = 1; e_rt = !artry_n; busy = 0; end
                    else if (!line_n) cack = 1;
                end else begin
                    if (age <= D && !hit_n) cache = 1;
                    if (!cache) begin
                        if (age == D) begin e_oe = 1; e_n = 0; end
                        else if (age == D + 1) e_n = 1;
                        else if (age == D + 2) begin
                            e_oe = 0; e_dv = 1; e_rt = !artry_n; busy = 0;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (d_oe !== e_oe || d_n !== e_n || dv !== e_dv || (e_dv && rt !== e_rt)) begin
                fails++;
                $display("FAIL %s: oe/n/valid/retry actual=%b%b%b%b expected=%b%b%b%b",
                         cur_req, d_oe, d_n, dv, rt, e_oe, e_n, e_dv, e_rt);
            end
            if (d_oe && c_oe) begin
                fails++;
                $display("FAIL R2: contention actual=both_driving expected=one_driver");
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            ts = 0; hit_n = 1; artry_n = 1; c_oe = 0; c_n = 1;
        end
    endtask

    // hit_age: edge offset of the claim (-1 none); gap: claim-to-ack distance
    task automatic tenure(input int hit_age, input int gap, input bit retry,
                          input int early_artry, input int ts_again, input string req);
        bit ch;
        int win, ca;
        cur_req = req;
        ch  = (hit_age >= 1 && hit_age <= D);
        ca  = hit_age + gap;
        win = ch ? ca + 1 : D + 2;
        @(negedge clk);
        ts = 1; hit_n = (hit_age == 0) ? 1'b0 : 1'b1;
        artry_n = 1; c_oe = 0; c_n = 1;
        for (int a = 1; a <= win; a++) begin
            @(negedge clk);
            ts    = (a == ts_again);
            hit_n = (a == hit_age) ? 1'b0 : 1'b1;
            c_oe  = ch && (a == ca || a == ca + 1);
            c_n   = !(a == ca);
            artry_n = !((retry && (a == win || a == win - 1)) || (a == early_artry));
        end
    endtask

    initial begin
        rst_n = 0; ts = 0; hit_n = 1; artry_n = 1; c_oe = 0; c_n = 1;
        repeat (3) @(negedge clk);
        checks++;
        if (d_oe !== 1'b0 || d_n !== 1'b1 || dv !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset oe/n/valid actual=%b%b%b expected=010", d_oe, d_n, dv);
        end
        rst_n = 1; started = 1;
        idle(2);
        tenure(-1, 0, 0, 0, 0, "R3");             // self ack, completed
        idle(2);
        tenure(-1, 0, 1, 0, 0, "R5");             // self ack, retried
        tenure(1, 1, 0, 0, 0, "R2");              // back to back, early claim
        idle(1);
        tenure(D, 3, 1, 0, 0, "R6");              // claim on last sample
        idle(1);
        tenure(0, 0, 0, 0, 0, "R7");              // claim with start ignored
        tenure(D + 1, 0, 0, 0, 0, "R7");          // claim after commit ignored
        idle(1);
        tenure(-1, 0, 0, D + 1, 0, "R9");         // retry outside window
        tenure(2, 2, 0, 3, 0, "R9");              // early retry on cached path
        tenure(-1, 0, 1, 0, 2, "R8");             // start while busy ignored
        tenure(2, 1, 0, 0, 3, "R8");
        tenure(-1, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 24; i++) begin
            int h;
            h = int'($urandom_range(0, D + 1)) - 1;
            tenure(h, int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)), 0, 0, "R6");
            idle(int'($urandom_range(0, 2)));
        end
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule